// File: doc/BRIEF.md
# Multiplexed External SRAM Bus Controller

This block takes CPU data-space requests whose address lies above the on-chip range (registers, I/O and internal SRAM end at $045F) and runs them on a narrow multiplexed bus. The high address byte goes out on its own pins. The low address byte shares the eight AD lines with data, and a one-cycle ALE pulse tells an external latch to capture it. Requests below $0460, and all requests while the interface is disabled, are left to the on-chip path: the controller keeps ready high and the bus stays quiet.

A 3-bit limit code splits the external space into a lower and an upper page. Each page has its own 2-bit wait setting, which stretches the read or write strobe and can add an address-hold cycle after it. The CPU keeps its request steady until it sees ready, so the controller needs no request buffer. The address and data pins change only in the cycle that carries ALE, or when write data is first driven onto AD. Between accesses they keep their last values.

Top module: `ext_sram_ctrl`

## Requirements
- R1: A request with `req_addr` >= $0460 while `ext_en`=1 starts an external access. Any lower address, or any request while `ext_en`=0, holds `req_ready`=1 in the same cycle and causes no ALE or strobe.
- R2: The cycle after an external request is accepted is the address phase. In it `ale`=1, `a_hi`=addr[15:8], `ad_out`=addr[7:0], `ad_oe`=1, and `rd_n`=`wr_n`=1. ALE lasts exactly one cycle.
- R3: The strobe phase follows the address phase. A read drives `rd_n`=0 with `ad_oe`=0. A write drives `wr_n`=0 with `ad_oe`=1 and `ad_out`=write data. `rd_n` and `wr_n` are never low together.
- R4: The strobe lasts 1+E cycles. The wait code sets E: code 0 gives E=0, code 1 gives E=1, code 2 gives E=2, and code 3 gives E=2.
- R5: Wait code 3 adds one hold cycle after the strobe. In it both strobes are high, ALE is low and `a_hi` is unchanged.
- R6: With `lim_code`=0 the upper-page wait code (`ws_hi`) applies to all external addresses. With `lim_code`=n (n from 1 to 7) the boundary is n×$2000. Addresses below the boundary use `ws_lo`, and all others use `ws_hi`.
- R7: During an external access `req_ready` is 0 from the request cycle through the strobe and hold cycles. It is 1 for the single completion cycle that follows.
- R8: For a read, `rsp_rdata` in the completion cycle equals the value on `ad_in` during the last strobe cycle.
- R9: `a_hi` changes only in an ALE cycle. `ad_out` changes only in an ALE cycle or in the first write-strobe cycle. Between accesses both keep their values and ALE stays low.
- R10: The page and wait settings are captured when the access starts. Changing `ws_lo`, `ws_hi` or `lim_code` during an access does not change its timing.
- R11: `bus_own` equals `ext_en`. It tells the port logic that the bus pins override their direction settings.
- R12: During and just after reset, `ale`=0, `rd_n`=`wr_n`=1, `ad_oe`=0 and `req_ready`=1 with no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_en | input | 1 | External interface enable |
| lim_code | input | 3 | Page boundary code (0 = single page) |
| ws_lo | input | 2 | Wait code, lower page |
| ws_hi | input | 2 | Wait code, upper page |
| req_valid | input | 1 | CPU request present |
| req_addr | input | 16 | CPU data-space address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8 | Write data |
| req_ready | output | 1 | Request complete / may advance |
| rsp_rdata | output | 8 | Read data, valid in completion cycle |
| bus_own | output | 1 | Bus pins overridden by the interface |
| ad_in | input | 8 | AD lines as read from the pins |
| ad_out | output | 8 | AD lines drive value |
| ad_oe | output | 1 | AD output enable |
| a_hi | output | 8 | High address byte pins |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
`req_ready` is combinational. It is checked 1 ns after the request is applied, in the same cycle. Every pin result is registered through the sequencer state. ALE and the address therefore appear one cycle after the request cycle, the strobe 2 cycles after it, any hold cycle follows the 1+E strobe cycles, and completion with read data comes one cycle later. The bench reference model computes those cycle positions from the wait code and the page of each address. It advances one clock at a time, sampling 2 ns after each rising edge, and compares every pin at each step. After each access, one further cycle confirms that the pins stay still until the next access.

// File: rtl/ext_bus_pkg.sv
// Shared types for the external SRAM bus controller.
// Assumes one outstanding request at a time; the CPU holds its request until ready.
package ext_bus_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_ADDR = 3'd1,
        ST_STRB = 3'd2,
        ST_HOLD = 3'd3,
        ST_DONE = 3'd4
    } bus_state_t;

    // Timing plan of one access: extra strobe cycles and optional hold cycle.
    typedef struct packed {
        logic [1:0] extra;
        logic       hold;
    } wait_plan_t;

    // Expand a 2-bit wait code into a timing plan.
    function automatic wait_plan_t plan_of(input logic [1:0] code);
        wait_plan_t p;
        p.hold  = (code == 2'd3);
        p.extra = (code == 2'd0) ? 2'd0 : (code == 2'd1) ? 2'd1 : 2'd2;
        return p;
    endfunction

endpackage

// File: rtl/ext_region_decode.sv
// Region decoder: decides whether an address is external and which page
// wait code applies. The boundary is lim × 2^(ADDR_W-LIM_W); lim = 0 means
// one page that uses the upper setting. Purely combinational.
module ext_region_decode
    import ext_bus_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          LIM_W    = 3,
    parameter int          WS_W     = 2,
    parameter logic [15:0] EXT_BASE = 16'h0460
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              ext_en,
    input  logic [LIM_W-1:0]  lim,
    input  logic [WS_W-1:0]   ws_lo,
    input  logic [WS_W-1:0]   ws_hi,
    output logic              hit,
    output wait_plan_t        plan
);
    localparam int PAGE_SHIFT = ADDR_W - LIM_W;

    logic upper;

    // External hit and page choice.
    always_comb begin
        hit   = ext_en && (addr >= ADDR_W'(EXT_BASE));
        upper = (lim == '0) || (addr[ADDR_W-1:PAGE_SHIFT] >= lim);
        plan  = plan_of(upper ? ws_hi : ws_lo);
    end
endmodule

// File: rtl/ext_bus_seq.sv
// Access sequencer: walks idle -> address -> strobe (1+extra) -> hold? -> done.
// Captures the timing plan at start so configuration changes mid-access
// have no effect. Ready is combinational from state and request.
module ext_bus_seq
    import ext_bus_pkg::*;
#(
    parameter int CNT_W = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic       hit,
    input  wait_plan_t plan_in,
    output bus_state_t state,
    output logic       start,
    output logic       last_strobe,
    output logic       req_ready,
    output logic       busy
);
    wait_plan_t       plan_q;
    logic [CNT_W-1:0] cnt;

    // Start and strobe-end decode.
    always_comb begin
        start       = (state == ST_IDLE) && req_valid && hit;
        last_strobe = (state == ST_STRB) && (cnt == CNT_W'(plan_q.extra));
        req_ready   = (state == ST_DONE) || ((state == ST_IDLE) && !(req_valid && hit));
        busy        = (state != ST_IDLE);
    end

    // State, wait counter and captured plan.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            plan_q <= '0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    state  <= ST_ADDR;
                    plan_q <= plan_in;
                    cnt    <= '0;
                end
                ST_ADDR: begin
                    state <= ST_STRB;
                    cnt   <= '0;
                end
                ST_STRB: begin
                    if (last_strobe) state <= plan_q.hold ? ST_HOLD : ST_DONE;
                    else             cnt   <= cnt + 1'b1;
                end
                ST_HOLD: state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/ext_pin_drive.sv
// Pin driver: latches address and write data at access start and keeps the
// pins steady until the next access. Strobes and ALE decode from the
// registered state, so they are glitch-free. Samples read data on the last
// strobe cycle.
module ext_pin_drive
    import ext_bus_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  bus_state_t               state,
    input  logic                     start,
    input  logic                     last_strobe,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_we,
    input  logic [DATA_W-1:0]        req_wdata,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n,
    output logic [DATA_W-1:0]        rdata
);
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;

    // Address, direction and data latches.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_hi    <= '0;
            ad_out  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
            rdata   <= '0;
        end else begin
            if (start) begin
                a_hi    <= req_addr[ADDR_W-1:DATA_W];
                ad_out  <= req_addr[DATA_W-1:0];
                we_q    <= req_we;
                wdata_q <= req_wdata;
            end
            if ((state == ST_ADDR) && we_q) ad_out <= wdata_q;
            if (last_strobe && !we_q)        rdata  <= ad_in;
        end
    end

    // Strobe, latch-enable and bus-direction decode.
    always_comb begin
        ale   = (state == ST_ADDR);
        rd_n  = !((state == ST_STRB) && !we_q);
        wr_n  = !((state == ST_STRB) && we_q);
        ad_oe = (state == ST_ADDR) || (we_q && ((state == ST_STRB) || (state == ST_HOLD)));
    end
endmodule

// File: rtl/ext_sram_ctrl.sv
// Top of the external SRAM bus controller: region decode, access sequencer
// and pin driver. Assumes the CPU keeps its request stable until req_ready.
module ext_sram_ctrl
    import ext_bus_pkg::*;
#(
    parameter int          ADDR_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          LIM_W    = 3,
    parameter int          WS_W     = 2,
    parameter logic [15:0] EXT_BASE = 16'h0460
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ext_en,
    input  logic [LIM_W-1:0]         lim_code,
    input  logic [WS_W-1:0]          ws_lo,
    input  logic [WS_W-1:0]          ws_hi,
    input  logic                     req_valid,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic                     req_we,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     req_ready,
    output logic [DATA_W-1:0]        rsp_rdata,
    output logic                     bus_own,
    input  logic [DATA_W-1:0]        ad_in,
    output logic [DATA_W-1:0]        ad_out,
    output logic                     ad_oe,
    output logic [ADDR_W-DATA_W-1:0] a_hi,
    output logic                     ale,
    output logic                     rd_n,
    output logic                     wr_n
);
    logic       hit, start, last_strobe, busy;
    wait_plan_t plan;
    bus_state_t state;

    // Pin ownership follows the enable.
    always_comb bus_own = ext_en;

    ext_region_decode #(
        .ADDR_W(ADDR_W), .LIM_W(LIM_W), .WS_W(WS_W), .EXT_BASE(EXT_BASE)
    ) u_dec (
        .addr(req_addr), .ext_en(ext_en), .lim(lim_code),
        .ws_lo(ws_lo), .ws_hi(ws_hi), .hit(hit), .plan(plan)
    );

    ext_bus_seq #(.CNT_W(2)) u_seq (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .hit(hit),
        .plan_in(plan), .state(state), .start(start),
        .last_strobe(last_strobe), .req_ready(req_ready), .busy(busy)
    );

    ext_pin_drive #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_pins (
        .clk(clk), .rst_n(rst_n), .state(state), .start(start),
        .last_strobe(last_strobe), .req_addr(req_addr), .req_we(req_we),
        .req_wdata(req_wdata), .ad_in(ad_in), .a_hi(a_hi), .ad_out(ad_out),
        .ad_oe(ad_oe), .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .rdata(rsp_rdata)
    );
endmodule

// File: rtl/ext_sram_ctrl_chk.sv
// Protocol checker for the external SRAM bus controller, bound to the top.
module ext_sram_ctrl_chk #(
    parameter int AHI_W  = 8,
    parameter int DATA_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ext_en,
    input logic             busy,
    input logic             req_ready,
    input logic             ale,
    input logic             rd_n,
    input logic             wr_n,
    input logic [AHI_W-1:0] a_hi,
    input logic [DATA_W-1:0] ad_out
);
    assert_ale_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_ale_no_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |-> (rd_n && wr_n));

    assert_busy_not_ready_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> !req_ready);

    assert_ahi_moves_with_ale_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(a_hi) |-> ale);

    assert_ad_moves_ok_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(ad_out) |-> (ale || !wr_n));

    assert_disabled_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ext_en) |-> (req_ready && !ale && rd_n && wr_n));
endmodule

bind ext_sram_ctrl ext_sram_ctrl_chk #(.AHI_W(ADDR_W-DATA_W), .DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .busy(busy),
    .req_ready(req_ready), .ale(ale), .rd_n(rd_n), .wr_n(wr_n),
    .a_hi(a_hi), .ad_out(ad_out)
);

// File: tb/ext_sram_ctrl_tb.sv
// Bench: behavioural cycle model of each access, compared every clock.
module ext_sram_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ext_en = 1'b0;
    logic [2:0]  lim_code = '0;
    logic [1:0]  ws_lo = '0, ws_hi = '0;
    logic        req_valid = 1'b0;
    logic [15:0] req_addr = '0;
    logic        req_we = 1'b0;
    logic [7:0]  req_wdata = '0;
    logic [7:0]  ad_in = '0;
    logic        req_ready, bus_own, ad_oe, ale, rd_n, wr_n;
    logic [7:0]  rsp_rdata, ad_out, a_hi;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    logic [7:0] exp_ahi = '0;
    logic [7:0] exp_ad = '0;

    always #2.5 clk = ~clk;

    ext_sram_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .ext_en(ext_en), .lim_code(lim_code),
        .ws_lo(ws_lo), .ws_hi(ws_hi), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_rdata(rsp_rdata), .bus_own(bus_own), .ad_in(ad_in), .ad_out(ad_out),
        .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .rd_n(rd_n), .wr_n(wr_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    // One CPU access; expected timing derived from the requirements.
    task automatic acc(input logic [15:0] a, input bit we, input logic [7:0] d,
                       input logic [7:0] rv, input bit disturb);
        bit       hit = ext_en && (a >= 16'h0460);
        int       bound = int'(lim_code) * 8192;
        bit       upper = (lim_code == 0) || (int'(a) >= bound);
        int       code = upper ? int'(ws_hi) : int'(ws_lo);
        int       extra = (code == 0) ? 0 : (code == 1) ? 1 : 2;
        bit       hold = (code == 3);
        logic [1:0] slo = ws_lo, shi = ws_hi;
        logic [2:0] slim = lim_code;
        req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d; ad_in = rv;
        #1;
        chk("R1/R7 ready in request cycle", req_ready, !hit);
        if (!hit) begin
            tick();
            chk("R1 no ale for on-chip", ale, 0);
            chk("R1 no strobe for on-chip", {rd_n, wr_n}, 2'b11);
            chk("R9 a_hi steady", a_hi, exp_ahi);
            req_valid = 1'b0;
            return;
        end
        tick();
        chk("R2 ale", ale, 1);
        chk("R2 a_hi", a_hi, a[15:8]);
        chk("R2 ad_out addr low", ad_out, a[7:0]);
        chk("R2 ad_oe", ad_oe, 1);
        chk("R2 strobes high", {rd_n, wr_n}, 2'b11);
        chk("R7 ready low addr", req_ready, 0);
        exp_ahi = a[15:8];
        if (disturb) begin
            ws_lo = ~slo; ws_hi = ~shi; lim_code = ~slim;
        end
        for (int s = 0; s <= extra; s++) begin
            tick();
            chk("R3 rd_n", rd_n, we);
            chk("R3 wr_n", wr_n, !we);
            chk("R3 ad_oe", ad_oe, we);
            if (we) chk("R3 write data", ad_out, d);
            chk("R4/R10 strobe length ready", req_ready, 0);
            chk("R2 ale low in strobe", ale, 0);
        end
        if (hold) begin
            tick();
            chk("R5 hold strobes", {rd_n, wr_n}, 2'b11);
            chk("R5 hold ale", ale, 0);
            chk("R5 hold a_hi", a_hi, a[15:8]);
            chk("R7 ready low hold", req_ready, 0);
        end
        tick();
        chk("R4/R5/R7 done ready", req_ready, 1);
        chk("R4/R6 done strobes", {rd_n, wr_n}, 2'b11);
        if (!we) chk("R8 read data", rsp_rdata, rv);
        exp_ad = we ? d : a[7:0];
        req_valid = 1'b0;
        ws_lo = slo; ws_hi = shi; lim_code = slim;
        ad_in = 8'hEE;
        tick();
        chk("R9 idle ale", ale, 0);
        chk("R9 idle a_hi", a_hi, exp_ahi);
        chk("R9 idle ad_out", ad_out, exp_ad);
        chk("R9 idle ready", req_ready, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(); tick();
        chk("R12 reset ale", ale, 0);
        chk("R12 reset strobes", {rd_n, wr_n}, 2'b11);
        chk("R12 reset ad_oe", ad_oe, 0);
        chk("R12 reset ready", req_ready, 1);
        rst_n = 1'b1;
        tick();
        chk("R12 after reset ale", ale, 0);
        chk("R11 bus_own off", bus_own, 0);
        ext_en = 1'b1; ws_hi = 2'd0; ws_lo = 2'd3; lim_code = 3'd0;
        #1 chk("R11 bus_own on", bus_own, 1);
        acc(16'h0100, 0, 8'h00, 8'h11, 0);        // R1 on-chip
        acc(16'h045F, 1, 8'h22, 8'h00, 0);        // R1 last on-chip address
        acc(16'h0460, 0, 8'h00, 8'h5A, 0);        // R1/R6 first external, lim 0 -> upper
        acc(16'h1234, 1, 8'hC3, 8'h00, 0);        // R6 lim 0 upper code 0
        lim_code = 3'd2; ws_lo = 2'd1; ws_hi = 2'd2;
        acc(16'h3FFF, 1, 8'hA5, 8'h00, 0);        // R6 below boundary, code 1
        acc(16'h4000, 0, 8'h00, 8'h3C, 0);        // R6 at boundary, code 2
        ws_lo = 2'd3;
        acc(16'h1234, 0, 8'h00, 8'h96, 0);        // R5 hold cycle read
        lim_code = 3'd7; ws_lo = 2'd2; ws_hi = 2'd3;
        acc(16'hDFFF, 0, 8'h00, 8'h81, 0);        // R6 top boundary lower
        acc(16'hE000, 1, 8'h7E, 8'h00, 0);        // R5/R6 upper with hold, write
        lim_code = 3'd1; ws_lo = 2'd0; ws_hi = 2'd1;
        acc(16'h8001, 0, 8'h00, 8'h4B, 1);        // R10 settings changed mid-access
        acc(16'h1000, 1, 8'h19, 8'h00, 1);        // R10 write, lower page
        ext_en = 1'b0;
        #1 chk("R11 bus_own follows", bus_own, 0);
        acc(16'h8000, 0, 8'h00, 8'h00, 0);        // R1 disabled
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule